// File: doc/BRIEF.md
# Cache-line fill memory timing controller

This block sits on the memory side of a cache and answers requests to fill one cache line. A line is four 32-bit words (16 bytes). A request carries a line address. The controller returns the four words of that line on the bus cycles that a chosen main-memory organization would need.

A two-bit mode code, captured with each request, selects one of three organizations:

- **Narrow:** a memory one word wide, read four times in turn.
- **Wide:** a memory four words wide with a bus four words wide.
- **Banked:** four banks one word wide, read in parallel, with the words then sent one per cycle over a one-word bus.

The read data comes from an internal read-only word array that holds a known arithmetic pattern. Each finished fill leaves its total length in cycles on an output. A bench can check the three miss penalties exactly from that output.

Requests use a valid/ready handshake, and only an idle controller accepts one. The response side has no back-pressure. A word appears on its lane for exactly one cycle, marked by its mask bit, and the requester must take it then. The address and mode are captured when the request is accepted. Request inputs have no effect while a fill is in progress.

Top module: `line_fill_timer`

## Requirements
- R1: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high when idle and goes low from the cycle after acceptance. `req_addr` and `req_mode` are captured at acceptance, and request inputs have no effect while a fill is in progress.
- R2: Bit w of `rsp_mask` marks that lane w, bits [32w+31:32w] of `rsp_data`, carries word w of the line. Lanes whose mask bit is low read zero. `rsp_valid` is high exactly when some mask bit is high, and each mask bit is high for a single cycle per fill.
- R3: Count the acceptance cycle as cycle 1. In mode code 0 (narrow), word w is returned alone in cycle 1 + 16(w+1), that is cycles 17, 33, 49 and 65, so a fill takes 65 cycles.
- R4: In mode code 1 (wide), all four words are returned together in cycle 17, with mask 4'b1111, so a fill takes 17 cycles.
- R5: In mode code 2 (banked), word w comes from bank w and is returned alone in cycle 17 + w, in ascending order, so a fill takes 20 cycles.
- R6: `rsp_last` is high in the cycle of the final transfer of a fill and in no other cycle.
- R7: From the cycle after the final transfer, `fill_cycles` holds the length of the fill just finished: cycle 1 through the final transfer, inclusive. It keeps that value until the next fill finishes.
- R8: Word w of line a has the value 32'h0100_0193 × (4a + w) + 32'h5A00_0C3E, modulo 2^32.
- R9: After reset, `req_ready` is 1, `rsp_valid` is 0, `rsp_last` is 0, `rsp_mask` is 0 and `fill_cycles` is 0.
- R10: Mode code 3 times a fill exactly as mode code 0 does.
- R11: `req_ready` returns high in the cycle right after the final transfer, and a new request can be accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Fill request present |
| req_ready | output | 1 | Controller idle; a request is accepted this cycle |
| req_addr | input | 4 | Line address |
| req_mode | input | 2 | Memory organization: 0 narrow, 1 wide, 2 banked, 3 as narrow |
| rsp_valid | output | 1 | At least one word lane carries data this cycle |
| rsp_mask | output | 4 | Per-lane word-present flags |
| rsp_data | output | 128 | Four word lanes, word w in lane w |
| rsp_last | output | 1 | Final transfer of the fill |
| fill_cycles | output | 7 | Length in cycles of the last finished fill |

## Verification
The bench keeps the default parameters: four 32-bit words per line, a 4-bit line address and the 1/15/1 cycle costs. With 16 lines, every line can be filled under all four mode codes, which is 64 fills and about 2,700 cycles. In every cycle of every fill the bench compares the mask, the data lanes, the last flag and the ready flag against a schedule worked out from the three penalty formulas. Fills run back to back, and every second fill drives a different address and mode while busy, to show those inputs have no effect.

// File: rtl/lft_pkg.sv
package lft_pkg;

  // Memory organization codes; any unlisted code times like the narrow case.
  typedef enum logic [1:0] {
    MODE_NARROW = 2'd0,
    MODE_WIDE   = 2'd1,
    MODE_BANKED = 2'd2,
    MODE_SPARE  = 2'd3
  } fill_mode_e;

endpackage

// File: rtl/lft_bank.sv
// One word-wide storage bank: holds word BANK_IDX of every line.
module lft_bank #(
  parameter int          WORD_W      = 32,
  parameter int          LINE_WORDS  = 4,
  parameter int          LINE_ADDR_W = 4,
  parameter int          BANK_IDX    = 0,
  parameter logic [31:0] PAT_MUL     = 32'h0100_0193,
  parameter logic [31:0] PAT_ADD     = 32'h5A00_0C3E
) (
  input  logic [LINE_ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0]      rd_data
);
  localparam int DEPTH = 1 << LINE_ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  initial begin
    for (int a = 0; a < DEPTH; a++) begin
      logic [31:0] v;
      v = PAT_MUL * 32'(a * LINE_WORDS + BANK_IDX) + PAT_ADD;
      mem[a] = WORD_W'(v);
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/lft_sched.sv
// Transfer schedule: which word lanes complete in the current fill cycle.
module lft_sched
  import lft_pkg::*;
#(
  parameter int LINE_WORDS = 4,
  parameter int ADDR_CYC   = 1,
  parameter int ACC_CYC    = 15,
  parameter int XFER_CYC   = 1,
  parameter int CNT_W      = 7
) (
  input  fill_mode_e            mode,
  input  logic [CNT_W-1:0]      cyc,
  output logic [LINE_WORDS-1:0] lane_hit
);
  for (genvar k = 0; k < LINE_WORDS; k++) begin : g_lane
    localparam int T_NARROW = ADDR_CYC + (k + 1) * (ACC_CYC + XFER_CYC);
    localparam int T_WIDE   = ADDR_CYC + ACC_CYC + XFER_CYC;
    localparam int T_BANKED = ADDR_CYC + ACC_CYC + (k + 1) * XFER_CYC;

    always_comb begin
      unique case (mode)
        MODE_WIDE:   lane_hit[k] = (cyc == CNT_W'(T_WIDE));
        MODE_BANKED: lane_hit[k] = (cyc == CNT_W'(T_BANKED));
        default:     lane_hit[k] = (cyc == CNT_W'(T_NARROW));
      endcase
    end
  end
endmodule

// File: rtl/lft_ctrl.sv
// Request capture, fill cycle counter and penalty latch.
module lft_ctrl
  import lft_pkg::*;
#(
  parameter int LINE_ADDR_W = 4,
  parameter int CNT_W       = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [LINE_ADDR_W-1:0] req_addr,
  input  logic [1:0]             req_mode,
  input  logic                   fill_end,
  output logic                   busy,
  output logic [CNT_W-1:0]       cyc,
  output logic [LINE_ADDR_W-1:0] addr_q,
  output fill_mode_e             mode_q,
  output logic [CNT_W-1:0]       fill_cycles
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      cyc         <= '0;
      addr_q      <= '0;
      mode_q      <= MODE_NARROW;
      fill_cycles <= '0;
    end else if (!busy) begin
      if (req_valid) begin
        busy   <= 1'b1;
        cyc    <= CNT_W'(2);  // acceptance cycle counts as cycle 1
        addr_q <= req_addr;
        mode_q <= fill_mode_e'(req_mode);
      end
    end else if (fill_end) begin
      busy        <= 1'b0;
      fill_cycles <= cyc;
    end else begin
      cyc <= cyc + CNT_W'(1);
    end
  end
endmodule

// File: rtl/line_fill_timer.sv
module line_fill_timer
  import lft_pkg::*;
#(
  parameter int          WORD_W      = 32,
  parameter int          LINE_WORDS  = 4,
  parameter int          LINE_ADDR_W = 4,
  parameter int          ADDR_CYC    = 1,
  parameter int          ACC_CYC     = 15,
  parameter int          XFER_CYC    = 1,
  parameter logic [31:0] PAT_MUL     = 32'h0100_0193,
  parameter logic [31:0] PAT_ADD     = 32'h5A00_0C3E,
  localparam int         NARROW_TOTAL = ADDR_CYC + LINE_WORDS * (ACC_CYC + XFER_CYC),
  localparam int         CNT_W        = $clog2(NARROW_TOTAL + 2)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [LINE_ADDR_W-1:0]       req_addr,
  input  logic [1:0]                   req_mode,
  output logic                         rsp_valid,
  output logic [LINE_WORDS-1:0]        rsp_mask,
  output logic [LINE_WORDS*WORD_W-1:0] rsp_data,
  output logic                         rsp_last,
  output logic [CNT_W-1:0]             fill_cycles
);
  logic                   busy;
  logic [CNT_W-1:0]       cyc;
  logic [LINE_ADDR_W-1:0] addr_q;
  fill_mode_e             mode_q;
  logic [LINE_WORDS-1:0]  lane_hit;
  logic                   fill_end;

  lft_ctrl #(.LINE_ADDR_W(LINE_ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_mode(req_mode), .fill_end(fill_end), .busy(busy), .cyc(cyc),
    .addr_q(addr_q), .mode_q(mode_q), .fill_cycles(fill_cycles)
  );

  lft_sched #(
    .LINE_WORDS(LINE_WORDS), .ADDR_CYC(ADDR_CYC), .ACC_CYC(ACC_CYC),
    .XFER_CYC(XFER_CYC), .CNT_W(CNT_W)
  ) u_sched (
    .mode(mode_q), .cyc(cyc), .lane_hit(lane_hit)
  );

  assign rsp_mask  = busy ? lane_hit : '0;
  assign fill_end  = rsp_mask[LINE_WORDS-1];  // highest lane always goes last
  assign rsp_last  = fill_end;
  assign rsp_valid = |rsp_mask;
  assign req_ready = !busy;

  for (genvar b = 0; b < LINE_WORDS; b++) begin : g_bank
    logic [WORD_W-1:0] word;
    lft_bank #(
      .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS), .LINE_ADDR_W(LINE_ADDR_W),
      .BANK_IDX(b), .PAT_MUL(PAT_MUL), .PAT_ADD(PAT_ADD)
    ) u_bank (
      .rd_addr(addr_q), .rd_data(word)
    );
    assign rsp_data[b*WORD_W +: WORD_W] = rsp_mask[b] ? word : '0;
  end
endmodule

// File: rtl/line_fill_timer_chk.sv
module line_fill_timer_chk #(
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int ADDR_CYC   = 1,
  parameter int ACC_CYC    = 15,
  parameter int XFER_CYC   = 1,
  parameter int CNT_W      = 7
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic                  rsp_valid,
  input logic [LINE_WORDS-1:0] rsp_mask,
  input logic                  rsp_last,
  input logic [CNT_W-1:0]      fill_cycles
);
  localparam int T_NARROW = ADDR_CYC + LINE_WORDS * (ACC_CYC + XFER_CYC);
  localparam int T_WIDE   = ADDR_CYC + ACC_CYC + XFER_CYC;
  localparam int T_BANKED = ADDR_CYC + ACC_CYC + LINE_WORDS * XFER_CYC;

  a_r1_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r1_no_ready_while_sending: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  a_r2_mask_shape: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones(rsp_mask) == 1 || rsp_mask == '1));

  a_r6_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_last |-> rsp_valid);

  a_r11_ready_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_last |=> req_ready);

  a_r7_count_legal: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_last |=> (fill_cycles == CNT_W'(T_NARROW) || fill_cycles == CNT_W'(T_WIDE) ||
                  fill_cycles == CNT_W'(T_BANKED)));

  a_r7_count_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_last |=> $stable(fill_cycles));
endmodule

bind line_fill_timer line_fill_timer_chk #(
  .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS), .ADDR_CYC(ADDR_CYC),
  .ACC_CYC(ACC_CYC), .XFER_CYC(XFER_CYC), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_mask(rsp_mask), .rsp_last(rsp_last),
  .fill_cycles(fill_cycles)
);

// File: tb/line_fill_timer_test.sv
module line_fill_timer_test;
  localparam int PERIOD = 10;
  localparam int WW = 32;
  localparam int NW = 4;
  localparam int AW = 4;
  localparam int ADDR_C = 1;
  localparam int ACC_C = 15;
  localparam int XFR_C = 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_mode = '0;
  logic          rsp_valid;
  logic [NW-1:0] rsp_mask;
  logic [NW*WW-1:0] rsp_data;
  logic          rsp_last;
  logic [6:0]    fill_cycles;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  line_fill_timer uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_mode(req_mode), .rsp_valid(rsp_valid),
    .rsp_mask(rsp_mask), .rsp_data(rsp_data), .rsp_last(rsp_last),
    .fill_cycles(fill_cycles)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] pat(input int a, input int w);
    return 32'h0100_0193 * 32'(4 * a + w) + 32'h5A00_0C3E;
  endfunction

  // Completion cycle of word w under mode code m (acceptance = cycle 1).
  function automatic int word_cyc(input int m, input int w);
    case (m)
      1: return ADDR_C + ACC_C + XFR_C;
      2: return ADDR_C + ACC_C + (w + 1) * XFR_C;
      default: return ADDR_C + (w + 1) * (ACC_C + XFR_C);  // codes 0 and 3 (R10)
    endcase
  endfunction

  int prev_total = 0;

  // Called at a negedge with the controller idle; returns at the negedge of
  // the cycle after the final transfer with req_valid low.
  task automatic do_fill(input int a, input int m, input bit junk);
    int last_c;
    string rq;
    last_c = word_cyc(m, NW - 1);
    rq = (m == 1) ? "R4" : (m == 2) ? "R5" : (m == 3) ? "R10" : "R3";
    chk("R11 ready before accept", 128'(req_ready), 128'(1));
    req_valid = 1'b1;
    req_addr  = AW'(a);
    req_mode  = 2'(m);
    @(posedge clk);
    for (int c = 2; c <= last_c + 1; c++) begin
      logic [NW-1:0] emask;
      logic [NW*WW-1:0] edata;
      @(negedge clk);
      if (c == 2) begin
        if (junk) begin
          req_addr = AW'(a ^ 5);
          req_mode = 2'((m + 1) % 4);
        end else begin
          req_valid = 1'b0;
        end
      end
      emask = '0;
      edata = '0;
      for (int w = 0; w < NW; w++)
        if (word_cyc(m, w) == c) begin
          emask[w] = 1'b1;
          edata[w*WW +: WW] = pat(a, w);  // R8
        end
      if (c <= last_c) begin
        chk({rq, " mask"}, 128'(rsp_mask), 128'(emask));
        chk({rq, " R2 R8 data"}, 128'(rsp_data), 128'(edata));
        chk("R2 valid", 128'(rsp_valid), 128'(emask != 0));
        chk("R6 last", 128'(rsp_last), 128'(c == last_c));
        chk(junk ? "R1 ready low, junk ignored" : "R1 ready low", 128'(req_ready), 128'(0));
        chk("R7 hold", 128'(fill_cycles), 128'(prev_total));
      end else begin
        req_valid = 1'b0;
        chk("R11 ready after last", 128'(req_ready), 128'(1));
        chk("R6 no valid after", 128'(rsp_valid), 128'(0));
        chk({"R7 penalty ", rq}, 128'(fill_cycles), 128'(last_c));
      end
    end
    prev_total = last_c;
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 ready", 128'(req_ready), 128'(1));
    chk("R9 valid", 128'(rsp_valid), 128'(0));
    chk("R9 last", 128'(rsp_last), 128'(0));
    chk("R9 mask", 128'(rsp_mask), 128'(0));
    chk("R9 count", 128'(fill_cycles), 128'(0));
    rst_n = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 4; m++) begin
      for (int a = 0; a < 16; a++) do_fill(a, m, a[0]);
      repeat (3) begin
        @(negedge clk);
        chk("R1 idle ready", 128'(req_ready), 128'(1));
        chk("R2 idle no valid", 128'(rsp_valid), 128'(0));
      end
    end
    // Known penalties, re-checked as plain numbers.
    do_fill(3, 0, 1'b0);
    chk("R3 narrow 65", 128'(fill_cycles), 128'(65));
    do_fill(7, 1, 1'b0);
    chk("R4 wide 17", 128'(fill_cycles), 128'(17));
    do_fill(9, 2, 1'b1);
    chk("R5 banked 20", 128'(fill_cycles), 128'(20));
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule